// File: doc/BRIEF.md
# Byte-Lane Enable and Port Acknowledge Controller

This block sits between a 32-bit processor bus that sizes its transfers on the fly and a single 32-bit memory bank made of four byte-wide devices. For each bus cycle it looks at the transfer size code, the two low address bits, the function code, one space-select address bit and the address and data strobes. From these it decides whether the bank is addressed and which of its four byte lanes take part in the transfer.

It drives one active-low enable per byte lane and an active-low bank select, and it passes the in-bank word address to the devices. When lanes are enabled it returns the two data-size acknowledge lines together, which tells the processor that the port is 32 bits wide. A parameter inserts 0 to 3 wait states. For a nonzero value a one-hot ring counter holds off the acknowledge, and that counter restarts every time the address strobe is released.

Top module: `lane_enable_ctrl`

## Requirements
- R1: `bankSelN` is low exactly when `asN` is low, `fc` equals 3'b101 and `addr[17]` is 0.
- R2: While `addr[17]` is 1, no lane enable is low, `bankSelN` is high and both acknowledge lines stay high.
- R3: No lane enable is low while `dsN` is high, whatever the other inputs are.
- R4: `sizeCode` gives the byte count as 01=1, 10=2, 11=3 and 00=4. The lane at byte offset o is driven by `laneEnN[3-o]`, so `laneEnN[3]` serves data bits 31..24 and `laneEnN[0]` serves bits 7..0. A selected transfer enables the lanes at offsets from `addr[1:0]` up to offset 3 or up to the last byte of the transfer, whichever comes first.
- R5: A two-byte transfer at offset 1 enables only the two middle lanes (`laneEnN` = 4'b1001).
- R6: With zero wait states, both bits of `ackN` go low in the same cycle as any lane enable does, and they stay high while no lane is enabled.
- R7: `memAddr` always equals `addr[16:2]`.
- R8: With WAIT_STATES = N > 0, `ackN` stays 2'b11 until N rising clock edges have passed with the bank selected. From then on it reads 2'b00 while a lane is enabled, and each new strobe assertion starts the count again.
- R9: In the same cycle that `asN` is high, every lane enable, `bankSelN` and both acknowledge lines are high. This also holds during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 32 | Processor address |
| sizeCode | input | 2 | Transfer size code |
| fc | input | 3 | Function code of the cycle |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| laneEnN | output | 4 | Active-low byte-lane enables, bit 3 = bits 31..24 |
| bankSelN | output | 1 | Active-low bank select |
| memAddr | output | 15 | Word address inside the bank |
| ackN | output | 2 | Data-size acknowledge pair, both low = 32-bit port |

## Verification
The lane enables, the bank select, the word address, the zero-wait acknowledge and the release on `asN` are all combinational. The bench therefore checks them one time step after it drives new inputs on a falling edge, before any clock edge can intervene. The delayed acknowledge changes only on rising edges. For it, the bench counts rising edges from the strobe assertion and samples on the following falling edge. After N-1 edges it expects the lines still high, and after N edges it expects them low. Between any two strobe assertions the strobe is released for a full cycle, so every sample also confirms that the ring counter restarted.

// File: rtl/lane_ctrl_pkg.sv
package lane_ctrl_pkg;
  typedef struct packed {
    logic bankHit;
    logic laneGate;
  } strobes_t;

  function automatic logic [2:0] sizeToBytes(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction
endpackage

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPACE_BIT = 17,
  parameter int LANES = 4,
  localparam int WORD_W = SPACE_BIT - 2
) (
  input  strobes_t           strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         sizeCode,
  output logic [LANES-1:0]   laneEnN,
  output logic               anyLane,
  output logic [WORD_W-1:0]  memAddr
);
  logic [3:0] firstOfs;
  logic [3:0] endOfs;
  logic [LANES-1:0] inSpan;

  assign firstOfs = {2'b00, addr[1:0]};
  assign endOfs   = firstOfs + {1'b0, sizeToBytes(sizeCode)};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [3:0] OFS = 4'(LANES - 1 - k);
    assign inSpan[k]  = (OFS >= firstOfs) && (OFS < endOfs);
    assign laneEnN[k] = ~(strb.laneGate & inSpan[k]);
  end

  assign anyLane = ~&laneEnN;
  assign memAddr = addr[SPACE_BIT-1:2];
endmodule

// File: rtl/lane_control.sv
module lane_control
  import lane_ctrl_pkg::*;
#(
  parameter int WAIT_STATES = 0,
  parameter logic [2:0] FC_SEL = 3'b101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       asN,
  input  logic       dsN,
  input  logic [2:0] fc,
  input  logic       spaceBit,
  input  logic       anyLane,
  output strobes_t   strb,
  output logic       bankSelN,
  output logic [1:0] ackN
);
  logic waitDone;

  assign strb.bankHit  = ~asN & (fc == FC_SEL) & ~spaceBit;
  assign strb.laneGate = strb.bankHit & ~dsN;
  assign bankSelN      = ~strb.bankHit;
  assign ackN          = {2{~(anyLane & waitDone)}};

  if (WAIT_STATES == 0) begin : g_nowait
    assign waitDone = 1'b1;
  end else begin : g_ring
    logic [WAIT_STATES:0] ring;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ring <= {{WAIT_STATES{1'b0}}, 1'b1};
      else if (asN) ring <= {{WAIT_STATES{1'b0}}, 1'b1};
      else if (strb.bankHit && !ring[WAIT_STATES]) ring <= {ring[WAIT_STATES-1:0], 1'b0};
    end
    assign waitDone = ring[WAIT_STATES];

    // R8: a delayed acknowledge needs the bank selected on the prior edge
    a_r8_ack_after_hit: assert property (@(posedge clk) disable iff (!rstN)
      (ackN == 2'b00) |-> $past(strb.bankHit));
    // R8: acknowledge never appears on the first cycle of a strobe
    a_r8_no_early_ack: assert property (@(posedge clk) disable iff (!rstN)
      $fell(asN) |-> (ackN == 2'b11));
  end

  // R6: both acknowledge lines always move together
  a_r6_ack_pair: assert property (@(posedge clk) disable iff (!rstN)
    ackN[1] == ackN[0]);
endmodule

// File: rtl/lane_enable_ctrl.sv
module lane_enable_ctrl
  import lane_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPACE_BIT = 17,
  parameter int WAIT_STATES = 0,
  localparam int WORD_W = SPACE_BIT - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        sizeCode,
  input  logic [2:0]        fc,
  input  logic              asN,
  input  logic              dsN,
  output logic [3:0]        laneEnN,
  output logic              bankSelN,
  output logic [WORD_W-1:0] memAddr,
  output logic [1:0]        ackN
);
  strobes_t strb;
  logic anyLane;

  lane_control #(.WAIT_STATES(WAIT_STATES), .FC_SEL(3'b101)) u_ctrl (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .fc(fc),
    .spaceBit(addr[SPACE_BIT]), .anyLane(anyLane),
    .strb(strb), .bankSelN(bankSelN), .ackN(ackN)
  );

  lane_datapath #(.ADDR_W(ADDR_W), .SPACE_BIT(SPACE_BIT), .LANES(4)) u_dp (
    .strb(strb), .addr(addr), .sizeCode(sizeCode),
    .laneEnN(laneEnN), .anyLane(anyLane), .memAddr(memAddr)
  );

  // R2: I/O space never touches memory lanes
  a_r2_io_space_idle: assert property (@(posedge clk) disable iff (!rstN)
    addr[SPACE_BIT] |-> (laneEnN == 4'hF && bankSelN && ackN == 2'b11));
  // R3: data strobe gates every lane
  a_r3_ds_gate: assert property (@(posedge clk) disable iff (!rstN)
    dsN |-> (laneEnN == 4'hF));
  // R6: acknowledge only with an enabled lane
  a_r6_ack_needs_lane: assert property (@(posedge clk) disable iff (!rstN)
    (ackN != 2'b11) |-> (laneEnN != 4'hF));
  // R9: released strobe leaves everything inactive
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> (laneEnN == 4'hF && bankSelN && ackN == 2'b11));
endmodule

// File: tb/sim_lane_enable_ctrl.sv
module sim_lane_enable_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0] sizeCode = '0;
  logic [2:0] fc = '0;
  logic asN = 1'b1, dsN = 1'b1;
  logic [3:0] en0, en1;
  logic sel0, sel1;
  logic [14:0] ma0, ma1;
  logic [1:0] ack0, ack1;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  lane_enable_ctrl #(.WAIT_STATES(2)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .sizeCode(sizeCode), .fc(fc),
    .asN(asN), .dsN(dsN), .laneEnN(en0), .bankSelN(sel0), .memAddr(ma0), .ackN(ack0));
  lane_enable_ctrl #(.WAIT_STATES(0)) u1 (
    .clk(clk), .rstN(rstN), .addr(addr), .sizeCode(sizeCode), .fc(fc),
    .asN(asN), .dsN(dsN), .laneEnN(en1), .bankSelN(sel1), .memAddr(ma1), .ackN(ack1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expMask(input int off, input logic [1:0] sz);
    int n = (sz == 2'b00) ? 4 : int'(sz);
    logic [3:0] m = '0;
    for (int o = 0; o < 4; o++) if (o >= off && o < off + n) m[3-o] = 1'b1;
    return m;
  endfunction

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset lanes", {28'd0, en0}, 32'hF);
    chk("R9 reset ack", {30'd0, ack0}, 32'h3);
    rstN = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 8; f++)
      for (int io = 0; io < 2; io++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 4; off++)
            for (int ds = 0; ds < 2; ds++) begin
              logic hit;
              logic [3:0] m;
              logic [31:0] a;
              a = $urandom;
              a[17] = io[0];
              a[1:0] = off[1:0];
              hit = (f == 5) && (io == 0);
              m = (hit && ds == 0) ? expMask(off, sz[1:0]) : 4'h0;
              addr = a; sizeCode = sz[1:0]; fc = f[2:0]; dsN = ds[0]; asN = 1'b0;
              #1;
              chk("R1 bank select", {31'd0, sel1}, {31'd0, ~hit});
              if (io == 1) chk("R2 io space lanes", {28'd0, en1}, 32'hF);
              if (ds == 1) chk("R3 ds gate", {28'd0, en1}, 32'hF);
              chk("R4 lane pattern", {28'd0, en1}, {28'd0, ~m});
              if (hit && ds == 0 && sz == 2 && off == 1)
                chk("R5 word at offset 1", {28'd0, en1}, 32'h9);
              chk("R6 zero-wait ack", {30'd0, ack1}, (m != 0) ? 32'h0 : 32'h3);
              chk("R7 word address", {17'd0, ma1}, {17'd0, a[16:2]});
              chk("R8 no ack at start", {30'd0, ack0}, 32'h3);
              @(posedge clk); @(negedge clk);
              chk("R8 ack after one edge", {30'd0, ack0}, 32'h3);
              @(posedge clk); @(negedge clk);
              chk("R8 ack after two edges", {30'd0, ack0}, (m != 0) ? 32'h0 : 32'h3);
              asN = 1'b1;
              #1;
              chk("R9 release lanes", {28'd0, en0}, 32'hF);
              chk("R9 release ack", {29'd0, sel0, ack0}, 32'h7);
              @(negedge clk);
            end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule